// File: doc/BRIEF.md
# Byte-Parity Dual-Port RAM

This block is a simple dual-port synchronous RAM in which every data byte is held together with one parity bit. One port only writes and one port only reads. A write takes an address, a data word, a per-byte lane mask and a strobe. Each selected lane computes even parity over its byte and stores the nine-bit result. Lanes left out of the mask are not touched.

A read takes an address and an enable. It returns the data word, the stored parity bits and one error flag per lane. Logic after the array computes each flag by checking the lane's nine bits again. Two parameters set the read timing:
- With neither set, the read is registered on the rising edge.
- `OUT_REG` adds a second output register.
- `FLOW` captures the read address on the falling edge and drives the array output straight out, so data arrives within the same cycle. When `FLOW` is set, `OUT_REG` is ignored.

A test input, `wr_par_flip`, stores inverted parity on a write. This lets error detection be exercised.

Top module: `bpram`

## Requirements
- R1: While reset is asserted, and after it until the first enabled read, the registered read modes (`FLOW`=0) drive `rd_data`, `rd_par` and `rd_err` to zero.
- R2: A write with `wr_par_flip`=0 stores, for each selected lane b, parity bit b. This bit equals the XOR of `wr_data[8b+7:8b]` (even parity), and a later read returns it on `rd_par[b]`.
- R3: Lane b is written only when `wr_en`=1 and `wr_be[b]`=1. Every other lane keeps both its old data byte and its old parity bit.
- R4: `rd_err[b]` is 1 exactly when the XOR of `rd_data[8b+7:8b]` differs from `rd_par[b]`. It is valid in the same cycle as `rd_data`.
- R5: A write with `wr_par_flip`=1 stores the inverted parity bit in every selected lane, so a later read of that lane reports `rd_err[b]`=1.
- R6: With `FLOW`=0 and `OUT_REG`=0, a read enabled at one rising edge shows its data after that edge.
- R7: With `FLOW`=0 and `OUT_REG`=1, the data of a read enabled at one rising edge appears after the following rising edge.
- R8: With `FLOW`=1, the read address and enable are captured on the falling edge, and the data is valid before the next rising edge.
- R9: A read of the address written in the same cycle returns the contents from before that write, in every mode.
- R10: With `rd_en`=0, the registered modes hold their read register and the flow-through mode keeps its captured address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of read registers |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 8*BYTES | Write data word |
| wr_be | input | BYTES | Per-lane write enable |
| wr_par_flip | input | 1 | Test: store inverted parity on this write |
| rd_en | input | 1 | Read enable |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8*BYTES | Read data word |
| rd_par | output | BYTES | Stored parity bits of the read word |
| rd_err | output | BYTES | Per-lane parity error flags |

## Verification
The hardest case to reach is a read and a write to the same address in one cycle, observed in all three read timings at once. This is worst in flow-through mode, where the old word must be sampled between the falling edge and the next rising edge. The bench drives three copies of the block, one per timing, from the same stimulus. It forces the collision directly and also lets random traffic with a small address space produce it often. Stored parity errors come from the flip input mixed with partial lane masks. These show that flagged and unflagged lanes within one word do not disturb each other.

// File: rtl/bpram.sv
module bpram #(
  parameter int ADDR_W  = 6,
  parameter int BYTES   = 4,
  parameter bit OUT_REG = 1'b0,
  parameter bit FLOW    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [8*BYTES-1:0]   wr_data,
  input  logic [BYTES-1:0]     wr_be,
  input  logic                 wr_par_flip,
  input  logic                 rd_en,
  input  logic [ADDR_W-1:0]    rd_addr,
  output logic [8*BYTES-1:0]   rd_data,
  output logic [BYTES-1:0]     rd_par,
  output logic [BYTES-1:0]     rd_err
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int W     = 9 * BYTES;

  logic [W-1:0] mem [DEPTH];
  logic [W-1:0] rword;

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BYTES; b++) begin
        if (wr_be[b])
          mem[wr_addr][b*9 +: 9] <= {(^wr_data[b*8 +: 8]) ^ wr_par_flip, wr_data[b*8 +: 8]};
      end
    end
  end

  generate
    if (FLOW) begin : g_flow
      logic [ADDR_W-1:0] ra_n;
      always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n)     ra_n <= '0;
        else if (rd_en) ra_n <= rd_addr;
      end
      assign rword = mem[ra_n];
    end else begin : g_sync
      logic [W-1:0] q1;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     q1 <= '0;
        else if (rd_en) q1 <= mem[rd_addr];
      end

      // R10
      rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(q1));

      // R9
      rd_old_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && wr_en && wr_addr == rd_addr) |=> q1 == $past(mem[rd_addr]));

      if (OUT_REG) begin : g_oreg
        logic [W-1:0] q2;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) q2 <= '0;
          else        q2 <= q1;
        end
        assign rword = q2;
      end else begin : g_noreg
        assign rword = q1;
      end
    end
  endgenerate

  genvar b;
  generate
    for (b = 0; b < BYTES; b++) begin : g_lane
      assign rd_data[b*8 +: 8] = rword[b*9 +: 8];
      assign rd_par[b]         = rword[b*9 + 8];
      assign rd_err[b]         = ^rword[b*9 +: 9];

      // R3
      lane_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_be[b]) |=> mem[$past(wr_addr)][b*9 +: 9] == $past(mem[wr_addr][b*9 +: 9]));

      // R2
      lane_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[b] && !wr_par_flip) |=> !(^mem[$past(wr_addr)][b*9 +: 9]));

      // R5
      lane_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_be[b] && wr_par_flip) |=> (^mem[$past(wr_addr)][b*9 +: 9]));
    end
  endgenerate
endmodule

// File: tb/bpram_tb.sv
module bpram_tb;
  localparam int AW = 6;
  localparam int NB = 4;
  localparam int DW = 8 * NB;
  localparam int RW = DW + 2 * NB;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_par_flip = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NB-1:0] wr_be = '0;

  logic [DW-1:0] d0, d1, d2;
  logic [NB-1:0] p0, p1, p2, e0, e1, e2;

  always #2.5 clk = ~clk;

  bpram #(.ADDR_W(AW), .BYTES(NB), .OUT_REG(1'b0), .FLOW(1'b0)) u_dut (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_be, .wr_par_flip, .rd_en, .rd_addr,
    .rd_data(d0), .rd_par(p0), .rd_err(e0));
  bpram #(.ADDR_W(AW), .BYTES(NB), .OUT_REG(1'b1), .FLOW(1'b0)) u_dut_r (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_be, .wr_par_flip, .rd_en, .rd_addr,
    .rd_data(d1), .rd_par(p1), .rd_err(e1));
  bpram #(.ADDR_W(AW), .BYTES(NB), .OUT_REG(1'b0), .FLOW(1'b1)) u_dut_f (
    .clk, .rst_n, .wr_en, .wr_addr, .wr_data, .wr_be, .wr_par_flip, .rd_en, .rd_addr,
    .rd_data(d2), .rd_par(p2), .rd_err(e2));

  int n_cmp = 0, n_bad = 0;
  logic [DW-1:0] mdat [1<<AW];
  logic [NB-1:0] mpar [1<<AW];
  logic [RW-1:0] x1 = '0, x2 = '0;
  logic [AW-1:0] fa = '0;
  string tag = "R1";

  function automatic logic [NB-1:0] par_of(input logic [DW-1:0] d);
    logic [NB-1:0] p;
    for (int b = 0; b < NB; b++) p[b] = ^d[b*8 +: 8];
    return p;
  endfunction

  // R4: flag = recomputed parity xor stored parity
  function automatic logic [RW-1:0] word_of(input logic [AW-1:0] a);
    return {par_of(mdat[a]) ^ mpar[a], mpar[a], mdat[a]};
  endfunction

  task automatic cmp(input string mode, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s/%s act=%h exp=%h", tag, mode, act, exp);
    end
  endtask

  // chk: 0 none, 1 registered modes, 2 all modes
  task automatic cyc(input logic we, input logic [AW-1:0] wa, input logic [DW-1:0] wd,
                     input logic [NB-1:0] be, input logic fl, input logic re,
                     input logic [AW-1:0] ra, input int chk);
    @(posedge clk);
    #1;
    wr_en = we; wr_addr = wa; wr_data = wd; wr_be = be; wr_par_flip = fl;
    rd_en = re; rd_addr = ra;
    #3;
    if (re) fa = ra;
    if (chk >= 1) begin
      cmp("R6", {e0, p0, d0}, x1);
      cmp("R7", {e1, p1, d1}, x2);
    end
    if (chk >= 2) cmp("R8", {e2, p2, d2}, word_of(fa));
    x2 = x1;
    if (re) x1 = word_of(ra);
    if (we) begin
      for (int b = 0; b < NB; b++) begin
        if (be[b]) begin
          mdat[wa][b*8 +: 8] = wd[b*8 +: 8];
          mpar[wa][b] = par_of(wd)[b] ^ fl;
        end
      end
    end
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tag = "R1";
    for (int a = 0; a < (1 << AW); a++)
      cyc(1'b1, AW'(a), $urandom, '1, 1'b0, 1'b0, '0, 1);

    tag = "R9";
    cyc(1'b1, 6'd5, 32'hA5A5_0F0F, '1, 1'b0, 1'b1, 6'd5, 2);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b1, 6'd5, 2);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 2);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 2);

    tag = "R5";
    cyc(1'b1, 6'd9, 32'h0102_0304, 4'b0101, 1'b1, 1'b0, '0, 2);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b1, 6'd9, 2);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 2);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 2);

    tag = "R3";
    cyc(1'b1, 6'd12, 32'hFFFF_FFFF, '1, 1'b0, 1'b0, '0, 2);
    cyc(1'b1, 6'd12, 32'h0000_0000, 4'b0010, 1'b0, 1'b0, '0, 2);
    cyc(1'b1, 6'd12, 32'h1234_5678, 4'b0000, 1'b1, 1'b1, 6'd12, 2);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 2);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b0, '0, 2);

    tag = "R10";
    cyc(1'b1, 6'd12, 32'hDEAD_BEEF, '1, 1'b0, 1'b0, 6'd3, 2);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b0, 6'd7, 2);
    cyc(1'b0, '0, '0, '0, 1'b0, 1'b0, 6'd8, 2);

    tag = "R4";
    for (int i = 0; i < 2000; i++) begin
      cyc($urandom_range(0, 1) == 1, AW'($urandom_range(0, 7)), $urandom, NB'($urandom),
          $urandom_range(0, 9) == 0, $urandom_range(0, 9) < 7, AW'($urandom_range(0, 7)), 2);
    end

    tag = "R2";
    for (int i = 0; i < 500; i++) begin
      cyc($urandom_range(0, 1) == 1, AW'($urandom), $urandom, '1, 1'b0,
          1'b1, AW'($urandom), 2);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule